// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block keeps the fetch-side state of a single hardware thread in an out-of-order core. Each cycle it looks at three groups of signals: stall requests from the four stages behind fetch, redirect requests from commit and from decode, and events from the instruction cache and the fetch datapath. From these it picks the next fetch status and keeps the thread's program counter. The fetch arbiter reads the status to decide whether the thread may be served this cycle. The cache side uses the drop indication to forget a miss that a redirect has made useless.

Every cycle resolves its inputs in one fixed order of precedence. A commit redirect comes first, then a commit-still-squashing hold, then a decode redirect, then stalls, then recovery to running, then cache fills, and last the action of being served. A fill only counts if its tag equals the tag recorded when the current miss began and the thread is still waiting on that miss.

Top module: `fetch_thread_ctrl`

## Requirements
- R1: After reset the status is Idle and PC holds RESET_PC, with next-PC equal to RESET_PC + 4. Status codes on `status`: Idle=0, Running=1, Squashing=2, Blocked=3, MissWait=4, MissDone=5, TrapWait=6, QuiesceWait=7.
- R2: Each stage index i (0..3) has a sticky stall flag. `stg_block[i]` sets it and `stg_unblock[i]` clears it, with the new value used in the same cycle. An unblock together with a block for the same stage, or an unblock of a clear flag, is a protocol error. While any flag or `ctx_stall` is set and the status is not MissWait, the next status is Blocked.
- R3: `cmt_squash` wins over every other input. PC takes `cmt_pc`, next-PC takes `cmt_pc` + 4, and the status becomes Squashing.
- R4: When there is no commit redirect, `cmt_busy` forces Squashing. It outranks a decode redirect and leaves PC unchanged.
- R5: `dec_squash` redirects PC to `dec_pc` and enters Squashing only when the status is not already Squashing. Otherwise it has no effect.
- R6: A thread in Blocked or Squashing with no redirect, hold or active stall returns to Running.
- R7: A fill (`fill_valid`) is accepted only in MissWait with `fill_tag` equal to the tag captured at miss start. It then leads to Blocked if a stall is active and to MissDone otherwise. A non-matching fill leaves the status in MissWait.
- R8: A redirect that takes effect while in MissWait raises `drop_miss` in that cycle. A later fill carrying the dropped tag does not lead to MissDone.
- R9: `served` in MissDone or Idle leads to Running, with no new miss, trap or quiesce taken in that cycle.
- R10: `served` in Running takes `miss_start` (capturing `miss_tag`, leading to MissWait) over `fault_evt` (leading to TrapWait) over `quiesce_evt` (leading to QuiesceWait). TrapWait and QuiesceWait persist until a redirect or a stall.
- R11: `status_chg` is high exactly in the cycles in which the status register takes a new value at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stg_block | input | NSTG | Per-stage stall set pulses |
| stg_unblock | input | NSTG | Per-stage stall clear pulses |
| ctx_stall | input | 1 | Context-switch stall level |
| cmt_squash | input | 1 | Redirect request from commit |
| cmt_pc | input | AW | Commit redirect target |
| cmt_busy | input | 1 | Commit still squashing |
| dec_squash | input | 1 | Redirect request from decode |
| dec_pc | input | AW | Decode redirect target |
| served | input | 1 | Thread chosen by the fetch arbiter this cycle |
| miss_start | input | 1 | Cache miss began on the served access |
| miss_tag | input | TW | Tag of the new miss |
| fault_evt | input | 1 | Translation fault on the served access |
| quiesce_evt | input | 1 | Quiesce instruction seen on the served access |
| fill_valid | input | 1 | Cache fill response |
| fill_tag | input | TW | Tag of the fill response |
| status | output | 3 | Current fetch status code |
| pc | output | AW | Current fetch PC |
| next_pc | output | AW | PC plus instruction size |
| drop_miss | output | 1 | Outstanding miss discarded this cycle |
| status_chg | output | 1 | Status changes at the next edge |

## Verification
The bench targets the fill that returns after a redirect has already dropped its miss. A design that forgot the drop would move to MissDone and resume at a stale line. It also sends a fill with the wrong tag while a miss is pending, which a design lacking the tag compare would wrongly accept. Redirects are combined in one cycle with stalls, holds and each other to expose a wrong precedence, for example a decode redirect that overrides the commit-still-squashing hold. It also covers a second decode redirect during Squashing, which must not move PC, and a stall raised during MissWait, which must not leave the miss until the fill arrives.

// File: rtl/fetch_ctl_pkg.sv
package fetch_ctl_pkg;
   typedef enum logic [2:0] {
      FS_IDLE     = 3'd0,
      FS_RUN      = 3'd1,
      FS_SQUASH   = 3'd2,
      FS_BLOCKED  = 3'd3,
      FS_MISSWAIT = 3'd4,
      FS_MISSDONE = 3'd5,
      FS_TRAP     = 3'd6,
      FS_QUIESCE  = 3'd7
   } fstate_e;
endpackage

// File: rtl/fc_stall_flags.sv
module fc_stall_flags #(
   parameter int NSTG = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSTG-1:0] blk,
   input  logic [NSTG-1:0] unblk,
   output logic [NSTG-1:0] flags_q,
   output logic [NSTG-1:0] flags_nxt
);
   if (NSTG < 1) begin : g_bad_nstg
      $error("fc_stall_flags: NSTG must be at least 1");
   end

   for (genvar i = 0; i < NSTG; i++) begin : g_flag
      assign flags_nxt[i] = (flags_q[i] | blk[i]) & ~unblk[i];
      always_ff @(posedge clk) begin
         if (!rst_n) flags_q[i] <= 1'b0;
         else        flags_q[i] <= flags_nxt[i];
      end
   end

   AST_UNBLK_WITH_BLK: assert property (@(posedge clk) disable iff (!rst_n)
      (blk & unblk) == '0);                                    // R2
   AST_UNBLK_UNSET: assert property (@(posedge clk) disable iff (!rst_n)
      (unblk & ~flags_q) == '0);                               // R2
   AST_BLK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (blk != '0) |=> ((flags_q & $past(blk)) == $past(blk))); // R2
endmodule

// File: rtl/fc_miss_tag.sv
module fc_miss_tag #(
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          capture,
   input  logic [TW-1:0] tag_in,
   input  logic          fill_valid,
   input  logic [TW-1:0] fill_tag,
   output logic          hit
);
   if (TW < 1) begin : g_bad_tw
      $error("fc_miss_tag: TW must be at least 1");
   end

   logic [TW-1:0] tag_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       tag_q <= '0;
      else if (capture) tag_q <= tag_in;
   end

   assign hit = fill_valid && (fill_tag == tag_q);
endmodule

// File: rtl/fc_pc_reg.sv
module fc_pc_reg #(
   parameter int          AW         = 32,
   parameter int          INST_BYTES = 4,
   parameter logic [31:0] RESET_PC   = 32'h0000_1000,
   parameter bit          REG_NEXT   = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] target,
   output logic [AW-1:0] pc,
   output logic [AW-1:0] next_pc
);
   localparam logic [AW-1:0] STEP  = AW'(INST_BYTES);
   localparam logic [AW-1:0] BOOT  = AW'(RESET_PC);

   if (AW < 8) begin : g_bad_aw
      $error("fc_pc_reg: AW must be at least 8");
   end
   if (INST_BYTES < 1) begin : g_bad_ib
      $error("fc_pc_reg: INST_BYTES must be positive");
   end

   logic [AW-1:0] pc_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    pc_q <= BOOT;
      else if (load) pc_q <= target;
   end
   assign pc = pc_q;

   if (REG_NEXT) begin : g_reg_next
      logic [AW-1:0] npc_q;
      always_ff @(posedge clk) begin
         if (!rst_n)    npc_q <= BOOT + STEP;
         else if (load) npc_q <= target + STEP;
      end
      assign next_pc = npc_q;
   end else begin : g_comb_next
      assign next_pc = pc_q + STEP;
   end
endmodule

// File: rtl/fc_status_fsm.sv
module fc_status_fsm
   import fetch_ctl_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    cmt_squash,
   input  logic    cmt_busy,
   input  logic    dec_squash,
   input  logic    stall,
   input  logic    fill_hit,
   input  logic    served,
   input  logic    miss_start,
   input  logic    fault_evt,
   input  logic    quiesce_evt,
   output fstate_e st_q,
   output fstate_e st_n,
   output logic    take_cmt,
   output logic    take_dec,
   output logic    capture,
   output logic    drop
);
   always_comb begin
      st_n     = st_q;
      take_cmt = 1'b0;
      take_dec = 1'b0;
      capture  = 1'b0;
      if (cmt_squash) begin
         take_cmt = 1'b1;
         st_n     = FS_SQUASH;
      end else if (cmt_busy) begin
         st_n = FS_SQUASH;
      end else if (dec_squash && st_q != FS_SQUASH) begin
         take_dec = 1'b1;
         st_n     = FS_SQUASH;
      end else if (stall && st_q != FS_MISSWAIT) begin
         st_n = FS_BLOCKED;
      end else if (st_q == FS_BLOCKED || st_q == FS_SQUASH) begin
         st_n = FS_RUN;
      end else if (st_q == FS_MISSWAIT) begin
         if (fill_hit) st_n = stall ? FS_BLOCKED : FS_MISSDONE;
      end else if (served) begin
         unique case (st_q)
            FS_IDLE, FS_MISSDONE: st_n = FS_RUN;
            FS_RUN: begin
               if (miss_start) begin
                  st_n    = FS_MISSWAIT;
                  capture = 1'b1;
               end else if (fault_evt) begin
                  st_n = FS_TRAP;
               end else if (quiesce_evt) begin
                  st_n = FS_QUIESCE;
               end
            end
            default: st_n = st_q;
         endcase
      end
   end

   assign drop = (take_cmt || take_dec) && (st_q == FS_MISSWAIT);

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= FS_IDLE;
      else        st_q <= st_n;
   end

   AST_MISSDONE_ONLY_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != FS_MISSWAIT && st_q != FS_MISSDONE) |=> (st_q != FS_MISSDONE)); // R7
   AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmt_busy && !cmt_squash) |=> (st_q == FS_SQUASH));                      // R4
   AST_DEC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_squash && !cmt_squash && !cmt_busy && st_q == FS_SQUASH) |-> !take_dec); // R5
   AST_TRAP_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == FS_TRAP && !cmt_squash && !cmt_busy && !dec_squash && !stall)
      |=> (st_q == FS_TRAP));                                                  // R10
endmodule

// File: rtl/fetch_thread_ctrl.sv
module fetch_thread_ctrl
   import fetch_ctl_pkg::*;
#(
   parameter int          AW         = 32,
   parameter int          TW         = 4,
   parameter int          NSTG       = 4,
   parameter int          INST_BYTES = 4,
   parameter logic [31:0] RESET_PC   = 32'h0000_1000,
   parameter bit          REG_NEXT   = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSTG-1:0] stg_block,
   input  logic [NSTG-1:0] stg_unblock,
   input  logic            ctx_stall,
   input  logic            cmt_squash,
   input  logic [AW-1:0]   cmt_pc,
   input  logic            cmt_busy,
   input  logic            dec_squash,
   input  logic [AW-1:0]   dec_pc,
   input  logic            served,
   input  logic            miss_start,
   input  logic [TW-1:0]   miss_tag,
   input  logic            fault_evt,
   input  logic            quiesce_evt,
   input  logic            fill_valid,
   input  logic [TW-1:0]   fill_tag,
   output logic [2:0]      status,
   output logic [AW-1:0]   pc,
   output logic [AW-1:0]   next_pc,
   output logic            drop_miss,
   output logic            status_chg
);
   logic [NSTG-1:0] flags_q, flags_nxt;
   logic            stall, fill_hit, take_cmt, take_dec, capture;
   fstate_e         st_q, st_n;
   logic [AW-1:0]   target;

   fc_stall_flags #(.NSTG(NSTG)) u_flags (
      .clk(clk), .rst_n(rst_n), .blk(stg_block), .unblk(stg_unblock),
      .flags_q(flags_q), .flags_nxt(flags_nxt));

   assign stall = (|flags_nxt) | ctx_stall;

   fc_miss_tag #(.TW(TW)) u_tag (
      .clk(clk), .rst_n(rst_n), .capture(capture), .tag_in(miss_tag),
      .fill_valid(fill_valid), .fill_tag(fill_tag), .hit(fill_hit));

   fc_status_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .cmt_squash(cmt_squash), .cmt_busy(cmt_busy),
      .dec_squash(dec_squash), .stall(stall), .fill_hit(fill_hit),
      .served(served), .miss_start(miss_start), .fault_evt(fault_evt),
      .quiesce_evt(quiesce_evt), .st_q(st_q), .st_n(st_n),
      .take_cmt(take_cmt), .take_dec(take_dec), .capture(capture),
      .drop(drop_miss));

   assign target = take_cmt ? cmt_pc : dec_pc;

   fc_pc_reg #(.AW(AW), .INST_BYTES(INST_BYTES), .RESET_PC(RESET_PC),
               .REG_NEXT(REG_NEXT)) u_pc (
      .clk(clk), .rst_n(rst_n), .load(take_cmt | take_dec), .target(target),
      .pc(pc), .next_pc(next_pc));

   assign status     = st_q;
   assign status_chg = (st_n != st_q);

   AST_CMT_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_squash |=> (pc == $past(cmt_pc)) && (status == FS_SQUASH));          // R3
   AST_NEXT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_squash |=> (next_pc == $past(cmt_pc) + AW'(INST_BYTES)));             // R3
   AST_DROP_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      drop_miss |-> (status == FS_MISSWAIT));                                  // R8
   AST_DROP_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
      drop_miss |=> (status == FS_SQUASH));                                    // R8
   AST_CHG_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      status_chg |=> (status != $past(status)));                               // R11
   AST_NOCHG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !status_chg |=> $stable(status));                                        // R11
   AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctx_stall && !cmt_squash && !cmt_busy && !dec_squash
       && status != FS_MISSWAIT) |=> (status == FS_BLOCKED));                  // R2
endmodule

// File: tb/sim_fetch_thread_ctrl.sv
`timescale 1ns/1ps
module sim_fetch_thread_ctrl;
   localparam int AW = 32;
   localparam int TW = 4;
   localparam logic [31:0] BOOT = 32'h0000_1000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [3:0]    stg_block = '0, stg_unblock = '0;
   logic          ctx_stall = 0, cmt_squash = 0, cmt_busy = 0, dec_squash = 0;
   logic [AW-1:0] cmt_pc = '0, dec_pc = '0;
   logic          served = 0, miss_start = 0, fault_evt = 0, quiesce_evt = 0;
   logic [TW-1:0] miss_tag = '0, fill_tag = '0;
   logic          fill_valid = 0;
   logic [2:0]    status;
   logic [AW-1:0] pc, next_pc;
   logic          drop_miss, status_chg;

   fetch_thread_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .stg_block(stg_block), .stg_unblock(stg_unblock),
      .ctx_stall(ctx_stall), .cmt_squash(cmt_squash), .cmt_pc(cmt_pc),
      .cmt_busy(cmt_busy), .dec_squash(dec_squash), .dec_pc(dec_pc),
      .served(served), .miss_start(miss_start), .miss_tag(miss_tag),
      .fault_evt(fault_evt), .quiesce_evt(quiesce_evt), .fill_valid(fill_valid),
      .fill_tag(fill_tag), .status(status), .pc(pc), .next_pc(next_pc),
      .drop_miss(drop_miss), .status_chg(status_chg));

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   // reference model state
   int            m_st;
   logic [AW-1:0] m_pc;
   logic [3:0]    m_flags;
   logic [TW-1:0] m_tag;

   task automatic chk(string req, string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic clear_in();
      stg_block = '0; stg_unblock = '0; ctx_stall = 0; cmt_squash = 0;
      cmt_busy = 0; dec_squash = 0; served = 0; miss_start = 0;
      fault_evt = 0; quiesce_evt = 0; fill_valid = 0;
   endtask

   // inputs already driven; compare, advance model, cross edge
   task automatic step(string req);
      int            nst;
      logic [AW-1:0] npc;
      logic [3:0]    nfl;
      logic [TW-1:0] ntag;
      bit            stl, drp;
      #1;
      nfl  = (m_flags | stg_block) & ~stg_unblock;
      stl  = (nfl != 0) || ctx_stall;
      nst  = m_st; npc = m_pc; ntag = m_tag; drp = 0;
      if (cmt_squash) begin
         nst = 2; npc = cmt_pc; drp = (m_st == 4);
      end else if (cmt_busy) nst = 2;
      else if (dec_squash && m_st != 2) begin
         nst = 2; npc = dec_pc; drp = (m_st == 4);
      end else if (stl && m_st != 4) nst = 3;
      else if (m_st == 3 || m_st == 2) nst = 1;
      else if (m_st == 4) begin
         if (fill_valid && fill_tag == m_tag) nst = stl ? 3 : 5;
      end else if (served) begin
         if (m_st == 0 || m_st == 5) nst = 1;
         else if (m_st == 1) begin
            if (miss_start) begin nst = 4; ntag = miss_tag; end
            else if (fault_evt) nst = 6;
            else if (quiesce_evt) nst = 7;
         end
      end
      chk(req, "status", status, m_st);
      chk(req, "pc", pc, m_pc);
      chk(req, "next_pc", next_pc, m_pc + 4);
      chk(req, "status_chg", status_chg, nst != m_st);
      chk(req, "drop_miss", drop_miss, drp);
      @(posedge clk);
      m_st = nst; m_pc = npc; m_flags = nfl; m_tag = ntag;
      @(negedge clk);
      clear_in();
   endtask

   initial begin
      #3_000_000;
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      m_st = 0; m_pc = BOOT; m_flags = '0; m_tag = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1", "status", status, 0);
      chk("R1", "pc", pc, BOOT);
      chk("R1", "next_pc", next_pc, BOOT + 4);
      // R9 idle served
      served = 1; step("R9");
      // R10 miss start, tag 5
      served = 1; miss_start = 1; miss_tag = 4'd5; step("R10");
      // R7 wrong tag ignored
      fill_valid = 1; fill_tag = 4'd3; step("R7");
      step("R7");
      fill_valid = 1; fill_tag = 4'd5; step("R7");
      served = 1; step("R9");
      // R2 stall during miss keeps MissWait; fill then goes Blocked
      served = 1; miss_start = 1; miss_tag = 4'd2; step("R10");
      stg_block = 4'b0010; step("R2");
      fill_valid = 1; fill_tag = 4'd2; step("R7");
      stg_unblock = 4'b0010; step("R6");
      step("R6");
      // R8 commit redirect drops miss, stale fill ignored
      served = 1; miss_start = 1; miss_tag = 4'd7; step("R10");
      cmt_squash = 1; cmt_pc = 32'h0000_2000; step("R8");
      fill_valid = 1; fill_tag = 4'd7; step("R8");
      step("R8");
      // R8 decode redirect also drops
      served = 1; miss_start = 1; miss_tag = 4'd9; step("R10");
      dec_squash = 1; dec_pc = 32'h0000_2400; step("R8");
      fill_valid = 1; fill_tag = 4'd9; step("R8");
      // R5 decode redirect, second one ignored while squashing
      dec_squash = 1; dec_pc = 32'h0000_3000; step("R5");
      dec_squash = 1; dec_pc = 32'h0000_4000; step("R5");
      step("R5");
      // R4 commit busy holds squashing, outranks decode
      cmt_busy = 1; step("R4");
      cmt_busy = 1; dec_squash = 1; dec_pc = 32'h0000_5000; step("R4");
      step("R4");
      step("R6");
      // R3 commit redirect wins over block and decode
      cmt_squash = 1; cmt_pc = 32'h0000_6000; stg_block = 4'b0001;
      dec_squash = 1; dec_pc = 32'h0000_7000; step("R3");
      step("R2");
      stg_unblock = 4'b0001; step("R2");
      step("R6");
      // R2 multiple flags
      stg_block = 4'b1001; step("R2");
      stg_unblock = 4'b0001; step("R2");
      step("R2");
      stg_unblock = 4'b1000; step("R2");
      step("R6");
      ctx_stall = 1; step("R2");
      step("R6");
      // R10 fault then persistence
      served = 1; fault_evt = 1; quiesce_evt = 1; step("R10");
      served = 1; step("R10");
      step("R10");
      dec_squash = 1; dec_pc = 32'h0000_8000; step("R10");
      step("R6");
      served = 1; quiesce_evt = 1; step("R10");
      served = 1; step("R10");
      stg_block = 4'b0100; step("R10");
      stg_unblock = 4'b0100; step("R6");
      step("R6");
      served = 1; miss_start = 1; fault_evt = 1; miss_tag = 4'd1; step("R10");
      fill_valid = 1; fill_tag = 4'd1; stg_block = 4'b0100; step("R7");
      stg_unblock = 4'b0100; step("R6");
      // R11 idle cycles with no change
      step("R11");
      step("R11");
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule